// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. One lookup consults two kinds of table at the same time. The first is a base table of 2-bit saturating counters that is indexed by the branch address alone. The second is a set of tagged tables. Each tagged table is indexed and tagged with a hash of the address and a slice of the global outcome history. Table `t` uses the newest `4 << t` history bits, so with four tables the slices are 4, 8, 16 and 32 bits long. The answer comes from the tagged table with the longest history that holds a matching entry. If no tagged table matches, the base table answers.

The lookup is purely combinational. Besides the guess, it returns the number of the providing source, the answer the next-best source would have given, and the index and tag it computed for every tagged table. The pipeline carries these values with the branch. When the branch resolves, it hands them back on the update port together with the real outcome. On that update the block does the following:
- It trains the provider's counter.
- It adjusts the provider's usefulness.
- After a wrong guess, it claims an entry in a longer-history table.
- It shifts the outcome into the global history.

Top module: `tage_pred`

## Requirements
- R1: After reset the history is all zero, every tagged entry is empty and every base counter holds 1. Every lookup therefore reports provider 0 and a not-taken guess.
- R2: The base counter is selected by the XOR-fold of the 16-bit address into 6 bits (address bit b lands on bit b mod 6). It predicts taken when its value is 2 or 3. It moves one step toward the outcome, saturating at 0 and 3, only on updates whose provider is 0.
- R3: Tagged table t uses a history length of 4<<t. Its 4-bit index is fold(address,16,4) XOR fold(history,len,4). Its 6-bit tag is fold(address,16,6) XOR fold(history,len,6). Here history bit 0 is the newest outcome, and pred_idx/pred_tag carry table t in bits [4t+3:4t] and [6t+5:6t].
- R4: A tagged table hits when its indexed entry is occupied and its stored tag equals the lookup tag. The provider number is 1 plus the highest-numbered hitting table, or 0 when nothing hits.
- R5: A tagged counter is 3-bit two's complement. It predicts taken when it is 0 or above. On updates naming its table as provider, it steps toward the outcome and saturates at -4 and +3.
- R6: After a wrong guess (upd_pred differs from upd_taken), the candidates are the tagged tables numbered at or above upd_provider. The lowest-numbered candidate whose indexed entry has usefulness 0 is rewritten as follows: it becomes occupied with upd_tag, its counter becomes 0 if the outcome was taken or -1 if not, and its usefulness becomes 0.
- R7: If no candidate has usefulness 0, every candidate's usefulness is lowered by one instead, and nothing is allocated.
- R8: The provider's 2-bit usefulness changes only when upd_pred differs from upd_alt. It rises (saturating at 3) when the guess was right and falls (saturating at 0) when it was wrong.
- R9: Each update shifts upd_taken into history bit 0. Lookups alone leave the history unchanged.
- R10: pred_alt is the guess of the second-highest hitting tagged table. With only one hit or none, it is the base table's guess.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 16 | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction |
| pred_alt | output | 1 | Direction the next-best source gives |
| pred_provider | output | 3 | 0 = base table, t+1 = tagged table t |
| pred_idx | output | 16 | Per-table indexes, 4 bits each |
| pred_tag | output | 24 | Per-table tags, 6 bits each |
| upd_valid | input | 1 | Apply one resolved branch this cycle |
| upd_pc | input | 16 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_pred | input | 1 | pred_taken returned from lookup time |
| upd_alt | input | 1 | pred_alt returned from lookup time |
| upd_provider | input | 3 | pred_provider returned from lookup time |
| upd_idx | input | 16 | pred_idx returned from lookup time |
| upd_tag | input | 24 | pred_tag returned from lookup time |

## Verification
The hardest situation to reach is a wrong guess in which every longer table's indexed entry already has nonzero usefulness. Only then do the usefulness values decay and the allocation get skipped. Usefulness only rises when the provider beats a different alternative, so reaching this case takes a crowd of addresses whose outcomes depend on older history bits. The bench therefore runs a long phase with many addresses and history-correlated outcomes, interleaved with rare flips. It counts both allocation and decay events in its own model, so that a run which never reached them is reported.

// File: rtl/tage_pkg.sv
// Shared helpers for the tagged direction predictor.
// Assumes addresses and history fit in 32 bits.
package tage_pkg;
    localparam int FOLD_SRC_W = 32;

    // XOR-folds the low nbits of src onto width bits (bit b goes to b mod width).
    function automatic logic [FOLD_SRC_W-1:0] fold_bits(input logic [FOLD_SRC_W-1:0] src,
                                                        input int nbits,
                                                        input int width);
        logic [FOLD_SRC_W-1:0] acc;
        acc = '0;
        for (int b = 0; b < FOLD_SRC_W; b++) begin
            if (b < nbits) acc[5'(b % width)] = acc[5'(b % width)] ^ src[b];
        end
        return acc;
    endfunction
endpackage

// File: rtl/tage_base.sv
// Base table of 2-bit saturating counters, read combinationally.
// Assumes only one update per cycle; reset writes weakly-not-taken (1).
module tage_base #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_taken,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_we,
    input  logic             up_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] ctr_q [DEPTH];

    // Purpose: direction is the counter's upper bit.
    assign lk_taken = ctr_q[lk_idx][1];

    // Purpose: reset all counters and step the addressed one toward the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= 2'd1;
        end else if (up_we) begin
            if (up_taken && ctr_q[up_idx] != 2'd3)
                ctr_q[up_idx] <= ctr_q[up_idx] + 2'd1;
            else if (!up_taken && ctr_q[up_idx] != 2'd0)
                ctr_q[up_idx] <= ctr_q[up_idx] - 2'd1;
        end
    end
endmodule

// File: rtl/tage_tbl.sv
// One tagged table: occupancy, partial tag, 3-bit signed counter, 2-bit useful.
// Assumes allocation and counter training never target the same update.
module tage_tbl #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_taken,
    input  logic [IDX_W-1:0] up_idx,
    output logic [1:0]       up_useful,
    input  logic             ctr_we,
    input  logic             ctr_taken,
    input  logic             u_inc,
    input  logic             u_dec,
    input  logic             alloc_we,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             alloc_taken
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [2:0] CTR_MAX = 3'b011;
    localparam logic [2:0] CTR_MIN = 3'b100;

    logic             vld_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [2:0]       ctr_q [DEPTH];
    logic [1:0]       use_q [DEPTH];

    // Purpose: tag match on an occupied entry; taken when the sign bit is clear.
    assign lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_taken  = ~ctr_q[lk_idx][2];
    assign up_useful = use_q[up_idx];

    // Purpose: clear occupancy on reset, then allocate or train one entry per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                ctr_q[i] <= '0;
                use_q[i] <= '0;
            end
        end else if (alloc_we) begin
            vld_q[up_idx] <= 1'b1;
            tag_q[up_idx] <= alloc_tag;
            ctr_q[up_idx] <= alloc_taken ? 3'b000 : 3'b111;
            use_q[up_idx] <= 2'd0;
        end else begin
            if (ctr_we) begin
                if (ctr_taken && ctr_q[up_idx] != CTR_MAX)
                    ctr_q[up_idx] <= ctr_q[up_idx] + 3'd1;
                else if (!ctr_taken && ctr_q[up_idx] != CTR_MIN)
                    ctr_q[up_idx] <= ctr_q[up_idx] - 3'd1;
            end
            if (u_inc && use_q[up_idx] != 2'd3)
                use_q[up_idx] <= use_q[up_idx] + 2'd1;
            else if (u_dec && use_q[up_idx] != 2'd0)
                use_q[up_idx] <= use_q[up_idx] - 2'd1;
        end
    end
endmodule

// File: rtl/tage_sel.sv
// Picks the provider (longest hitting table) and the alternate guess.
// Assumes table numbers rise with history length.
module tage_sel #(
    parameter int NUM_T  = 4,
    parameter int PROV_W = 3
) (
    input  logic [NUM_T-1:0]  hit,
    input  logic [NUM_T-1:0]  taken,
    input  logic              base_taken,
    output logic [PROV_W-1:0] provider,
    output logic              pred,
    output logic              alt
);
    // Purpose: scan from the longest history down; first hit provides, second is alternate.
    always_comb begin
        logic got_first;
        logic got_second;
        provider   = '0;
        pred       = base_taken;
        alt        = base_taken;
        got_first  = 1'b0;
        got_second = 1'b0;
        for (int j = NUM_T - 1; j >= 0; j--) begin
            if (hit[j]) begin
                if (!got_first) begin
                    provider  = PROV_W'(j + 1);
                    pred      = taken[j];
                    got_first = 1'b1;
                end else if (!got_second) begin
                    alt        = taken[j];
                    got_second = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tage_pred.sv
// Top of the tagged geometric-history direction predictor.
// Lookup is combinational from lk_pc and the committed history; the history
// advances only on resolved updates, one update per cycle at most.
module tage_pred #(
    parameter int PC_W       = 16,
    parameter int NUM_T      = 4,
    parameter int BASE_HIST  = 4,
    parameter int BASE_IDX_W = 6,
    parameter int T_IDX_W    = 4,
    parameter int TAG_W      = 6,
    parameter int PROV_W     = $clog2(NUM_T + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PC_W-1:0]          lk_pc,
    output logic                     pred_taken,
    output logic                     pred_alt,
    output logic [PROV_W-1:0]        pred_provider,
    output logic [NUM_T*T_IDX_W-1:0] pred_idx,
    output logic [NUM_T*TAG_W-1:0]   pred_tag,
    input  logic                     upd_valid,
    input  logic [PC_W-1:0]          upd_pc,
    input  logic                     upd_taken,
    input  logic                     upd_pred,
    input  logic                     upd_alt,
    input  logic [PROV_W-1:0]        upd_provider,
    input  logic [NUM_T*T_IDX_W-1:0] upd_idx,
    input  logic [NUM_T*TAG_W-1:0]   upd_tag
);
    import tage_pkg::*;

    localparam int HIST_W = BASE_HIST << (NUM_T - 1);

    logic [HIST_W-1:0]     ghist;
    logic [FOLD_SRC_W-1:0] hist_ext;
    logic [FOLD_SRC_W-1:0] lk_pc_ext;
    logic [FOLD_SRC_W-1:0] up_pc_ext;
    logic [NUM_T-1:0]      t_hit;
    logic [NUM_T-1:0]      t_taken;
    logic [NUM_T-1:0]      cand;
    logic [NUM_T-1:0]      free_slot;
    logic [NUM_T-1:0]      chosen;
    logic [1:0]            t_useful [NUM_T];
    logic                  base_taken;
    logic                  mispred;
    logic                  alt_differs;
    logic                  any_free;

    // Purpose: global outcome history, newest outcome in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)         ghist <= '0;
        else if (upd_valid) ghist <= {ghist[HIST_W-2:0], upd_taken};
    end

    // Purpose: widen history and addresses to the folding width.
    always_comb begin
        hist_ext  = '0;
        lk_pc_ext = '0;
        up_pc_ext = '0;
        hist_ext[HIST_W-1:0] = ghist;
        lk_pc_ext[PC_W-1:0]  = lk_pc;
        up_pc_ext[PC_W-1:0]  = upd_pc;
    end

    tage_base #(.IDX_W(BASE_IDX_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (BASE_IDX_W'(fold_bits(lk_pc_ext, PC_W, BASE_IDX_W))),
        .lk_taken (base_taken),
        .up_idx   (BASE_IDX_W'(fold_bits(up_pc_ext, PC_W, BASE_IDX_W))),
        .up_we    (upd_valid && (upd_provider == '0)),
        .up_taken (upd_taken)
    );

    // Purpose: common update conditions.
    assign mispred     = upd_pred != upd_taken;
    assign alt_differs = upd_pred != upd_alt;

    // Purpose: tables at or above the provider number are allocation candidates.
    always_comb begin
        for (int t = 0; t < NUM_T; t++) begin
            cand[t]      = upd_valid && mispred && (PROV_W'(t) >= upd_provider);
            free_slot[t] = cand[t] && (t_useful[t] == 2'd0);
        end
    end

    // Purpose: the lowest-numbered free candidate receives the new entry.
    always_comb begin
        logic seen;
        seen   = 1'b0;
        chosen = '0;
        for (int t = 0; t < NUM_T; t++) begin
            if (free_slot[t] && !seen) begin
                chosen[t] = 1'b1;
                seen      = 1'b1;
            end
        end
    end
    assign any_free = |free_slot;

    for (genvar t = 0; t < NUM_T; t++) begin : g_tbl
        localparam int LEN = BASE_HIST << t;
        logic is_prov;

        // Purpose: per-table lookup hash of address and its history slice.
        assign pred_idx[t*T_IDX_W +: T_IDX_W] =
            T_IDX_W'(fold_bits(lk_pc_ext, PC_W, T_IDX_W) ^ fold_bits(hist_ext, LEN, T_IDX_W));
        assign pred_tag[t*TAG_W +: TAG_W] =
            TAG_W'(fold_bits(lk_pc_ext, PC_W, TAG_W) ^ fold_bits(hist_ext, LEN, TAG_W));
        assign is_prov = upd_valid && (upd_provider == PROV_W'(t + 1));

        tage_tbl #(.IDX_W(T_IDX_W), .TAG_W(TAG_W)) u_tbl (
            .clk         (clk),
            .rst_n       (rst_n),
            .lk_idx      (pred_idx[t*T_IDX_W +: T_IDX_W]),
            .lk_tag      (pred_tag[t*TAG_W +: TAG_W]),
            .lk_hit      (t_hit[t]),
            .lk_taken    (t_taken[t]),
            .up_idx      (upd_idx[t*T_IDX_W +: T_IDX_W]),
            .up_useful   (t_useful[t]),
            .ctr_we      (is_prov),
            .ctr_taken   (upd_taken),
            .u_inc       (is_prov && alt_differs && !mispred),
            .u_dec       ((is_prov && alt_differs && mispred) || (cand[t] && !any_free)),
            .alloc_we    (chosen[t]),
            .alloc_tag   (upd_tag[t*TAG_W +: TAG_W]),
            .alloc_taken (upd_taken)
        );
    end

    tage_sel #(.NUM_T(NUM_T), .PROV_W(PROV_W)) u_sel (
        .hit        (t_hit),
        .taken      (t_taken),
        .base_taken (base_taken),
        .provider   (pred_provider),
        .pred       (pred_taken),
        .alt        (pred_alt)
    );
endmodule

// File: rtl/tage_pred_chk.sv
// Property checker for tage_pred, attached by bind below.
module tage_pred_chk #(
    parameter int NUM_T  = 4,
    parameter int PROV_W = 3,
    parameter int HIST_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PROV_W-1:0] pred_provider,
    input logic [NUM_T-1:0]  t_hit,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] ghist
);
    assert_hist_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ghist[0] == $past(upd_taken));
    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist));
    assert_prov_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_provider <= PROV_W'(NUM_T));
    assert_prov_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_provider != '0) |-> ((t_hit >> (pred_provider - 1'b1)) & NUM_T'(1)) != '0);
    assert_prov_longest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_hit >> pred_provider) == '0);
    assert_no_hit_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_hit == '0) |-> (pred_provider == '0));
endmodule

bind tage_pred tage_pred_chk #(.NUM_T(NUM_T), .PROV_W(PROV_W), .HIST_W(HIST_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pred_provider (pred_provider),
    .t_hit         (t_hit),
    .upd_valid     (upd_valid),
    .upd_taken     (upd_taken),
    .ghist         (ghist)
);

// File: tb/tb_tage_pred.sv
`timescale 1ns/1ps
module tb_tage_pred;
    localparam int CYC = 20;
    localparam int NT  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lk_pc = '0;
    logic        pred_taken, pred_alt;
    logic [2:0]  pred_provider;
    logic [15:0] pred_idx;
    logic [23:0] pred_tag;
    logic        upd_valid = 1'b0;
    logic [15:0] upd_pc = '0;
    logic        upd_taken = 1'b0, upd_pred = 1'b0, upd_alt = 1'b0;
    logic [2:0]  upd_provider = '0;
    logic [15:0] upd_idx = '0;
    logic [23:0] upd_tag = '0;

    int n_run = 0, n_fail = 0, n_alloc = 0, n_decay = 0;
    bit finished = 1'b0;

    // Reference state, built from the requirements.
    int          m_base [64];
    bit          m_v   [NT][16];
    int          m_tag [NT][16];
    int          m_c   [NT][16];
    int          m_u   [NT][16];
    logic [31:0] m_h;

    always #(CYC/2) clk = ~clk;

    tage_pred dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
        .pred_taken(pred_taken), .pred_alt(pred_alt), .pred_provider(pred_provider),
        .pred_idx(pred_idx), .pred_tag(pred_tag),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_pred(upd_pred), .upd_alt(upd_alt), .upd_provider(upd_provider),
        .upd_idx(upd_idx), .upd_tag(upd_tag)
    );

    function automatic int bfold(logic [31:0] x, int n, int w);
        int r = 0;
        for (int b = 0; b < n; b++) if (x[b]) r = r ^ (1 << (b % w));
        return r;
    endfunction

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_base[i] = 1;
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < 16; i++) begin
                m_v[t][i] = 0; m_tag[t][i] = 0; m_c[t][i] = 0; m_u[t][i] = 0;
            end
        m_h = '0;
    endtask

    // One branch: lookup and compare, then resolve with the given outcome.
    task automatic branch(logic [15:0] pc, bit outcome, bit do_update);
        int e_idx [NT];
        int e_tag [NT];
        int e_prov, bidx, first, cands;
        bit e_pred, e_alt, base_t, got;
        @(negedge clk);
        lk_pc = pc;
        upd_valid = 1'b0;
        #2;
        bidx   = bfold({16'h0, pc}, 16, 6);
        base_t = (m_base[bidx] >= 2);
        e_prov = 0; e_pred = base_t; e_alt = base_t; got = 0;
        for (int t = 0; t < NT; t++) begin
            e_idx[t] = bfold({16'h0, pc}, 16, 4) ^ bfold(m_h, 4 << t, 4);
            e_tag[t] = bfold({16'h0, pc}, 16, 6) ^ bfold(m_h, 4 << t, 6);
        end
        for (int t = NT - 1; t >= 0; t--) begin
            if (m_v[t][e_idx[t]] && m_tag[t][e_idx[t]] == e_tag[t]) begin
                if (e_prov == 0) begin
                    e_prov = t + 1; e_pred = (m_c[t][e_idx[t]] >= 0);
                end else if (!got) begin
                    e_alt = (m_c[t][e_idx[t]] >= 0); got = 1;
                end
            end
        end
        for (int t = 0; t < NT; t++) begin
            check("R3 R9 index", int'(pred_idx[t*4 +: 4]), e_idx[t]);
            check("R3 R9 tag", int'(pred_tag[t*6 +: 6]), e_tag[t]);
        end
        check("R4 R6 R7 R8 provider", int'(pred_provider), e_prov);
        check((e_prov == 0) ? "R2 R1 base guess" : "R5 tagged guess", int'(pred_taken), int'(e_pred));
        check("R10 alternate", int'(pred_alt), int'(e_alt));
        if (!do_update) return;
        upd_pc = pc; upd_taken = outcome; upd_pred = pred_taken; upd_alt = pred_alt;
        upd_provider = pred_provider; upd_idx = pred_idx; upd_tag = pred_tag;
        upd_valid = 1'b1;
        // Model update per R2, R5..R9.
        if (e_prov == 0) begin
            if (outcome && m_base[bidx] < 3) m_base[bidx]++;
            if (!outcome && m_base[bidx] > 0) m_base[bidx]--;
        end else begin
            int t = e_prov - 1, i = e_idx[e_prov - 1];
            if (outcome && m_c[t][i] < 3) m_c[t][i]++;
            if (!outcome && m_c[t][i] > -4) m_c[t][i]--;
            if (e_pred != e_alt) begin
                if (e_pred == outcome && m_u[t][i] < 3) m_u[t][i]++;
                if (e_pred != outcome && m_u[t][i] > 0) m_u[t][i]--;
            end
        end
        if (e_pred != outcome) begin
            first = -1; cands = 0;
            for (int t = e_prov; t < NT; t++) begin
                cands++;
                if (first < 0 && m_u[t][e_idx[t]] == 0) first = t;
            end
            if (first >= 0) begin
                m_v[first][e_idx[first]] = 1; m_tag[first][e_idx[first]] = e_tag[first];
                m_c[first][e_idx[first]] = outcome ? 0 : -1; m_u[first][e_idx[first]] = 0;
                n_alloc++;
            end else if (cands > 0) begin
                for (int t = e_prov; t < NT; t++)
                    if (m_u[t][e_idx[t]] > 0) m_u[t][e_idx[t]]--;
                n_decay++;
            end
        end
        m_h = {m_h[30:0], outcome};
        @(posedge clk);
        #1 upd_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: lookups after reset, no updates; every address answers from the base.
        for (int i = 0; i < 64; i++) branch(16'(i * 37), 1'b0, 1'b0);
        // R9: lookups alone left history at zero; index equals the address fold.
        branch(16'h0123, 1'b0, 1'b0);
        // Loop-shaped branch: seven taken then one not taken (R2, R5, R6).
        for (int i = 0; i < 400; i++) branch(16'h0120, (i % 8) != 7, 1'b1);
        // Always-taken branch drives counters into saturation (R2, R5).
        for (int i = 0; i < 60; i++) branch(16'h4444, 1'b1, 1'b1);
        // Alternating pair whose outcome depends on history (R6, R8, R10).
        for (int i = 0; i < 400; i++) branch((i % 2) ? 16'h0A10 : 16'h0B22, m_h[1] ^ m_h[3], 1'b1);
        // Many addresses, history-correlated outcomes with rare flips (R7, R8).
        for (int i = 0; i < 2500; i++) begin
            bit o;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            o = m_h[2] ^ m_h[7] ^ lfsr[9];
            if (lfsr[4:0] == 5'd0) o = ~o;
            branch({lfsr[15:12], 4'h0, lfsr[3:0], 4'h8}, o, 1'b1);
        end
        // Reset again: state returns to the R1 condition.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        for (int i = 0; i < 16; i++) branch(16'(i * 911), 1'b0, 1'b0);
        check("R6 allocation events reached", int'(n_alloc > 0), 1);
        check("R7 decay events reached", int'(n_decay > 0), 1);
        $display("[TB] allocations %0d, decays %0d", n_alloc, n_decay);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CYC * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule